// File: doc/BRIEF.md
# Dual-Mode FIFO with Programmable Flags

A single-clock FIFO of 18-bit words with a parameterised depth. A mode pin is captured while reset is held and fixes the read timing until the next reset. In standard timing, every word, the first one included, leaves the FIFO on a read request. In fall-through timing, the oldest word is placed on the data output with no request, so the output register holds one more word and the capacity becomes DEPTH+1.

Two shared flag pins change their meaning with the mode. In standard timing they are an active-low empty flag and an active-low full flag. In fall-through timing they are an active-low output-ready flag and an input-ready flag that goes high when the FIFO is full. Three threshold flags are present in both modes: almost-empty, half-full and almost-full. Two offset registers set the almost-empty and almost-full thresholds. A default-select pin captured during reset chooses their reset values, and a small write port can change them later.

Top module: `dm_fifo`

## Requirements
- R1: `fwft_mode_i` is captured on every clock edge while `rst_ni` is low, with 0 selecting standard timing and 1 selecting fall-through timing. Changes on the pin while out of reset have no effect.
- R2: In standard mode, `rd_flag_o` (empty, active low) reads 0 after reset. It goes to 1 on the edge that stores the first word and returns to 0 on the edge that reads the last word.
- R3: In standard mode, `wr_flag_o` (full, active low) goes to 0 once DEPTH words are stored. The first read from full sets it back to 1.
- R4: In fall-through mode, `rd_flag_o` (output-ready, active low) goes to 0 two edges after the first write, with `ren_ni` held high, and at that point `dout_o` holds that word. It returns to 1 on the edge that consumes the last word.
- R5: In fall-through mode, the capacity is DEPTH+1 words, and `wr_flag_o` reads 1 exactly while DEPTH+1 words are held.
- R6: With empty offset n and occupancy k (the output register counts as one word in fall-through mode), `almost_empty_no` is 1 when k ≥ n+1 in standard mode and when k ≥ n+2 in fall-through mode.
- R7: `half_full_no` is 0 when k ≥ DEPTH/2+1 in standard mode and when k ≥ DEPTH/2+2 in fall-through mode.
- R8: With full offset m, `almost_full_no` is 0 when k ≥ DEPTH−m in standard mode and when k ≥ DEPTH+1−m in fall-through mode.
- R9: A read request while empty changes no state, and a write while full is dropped: the occupancy does not change and the dropped word never appears at the output.
- R10: `dflt_sel_i` is captured during reset. A value of 1 loads both offsets with 0x3FF and a value of 0 loads both with 0x07F, each limited to DEPTH−1.
- R11: When `ofs_we_i` is 1 out of reset, `ofs_val_i` is written to the empty offset (`ofs_sel_i`=0) or to the full offset (`ofs_sel_i`=1). The flags use the new value from the following edge.
- R12: In fall-through mode, the output register reloads from storage on the same edge that consumes a word, so reads held active deliver one word per clock.
- R13: Words leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous assert |
| fwft_mode_i | input | 1 | Timing mode, captured during reset |
| dflt_sel_i | input | 1 | Default-offset select, captured during reset |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| din_i | input | 18 | Write data |
| ofs_we_i | input | 1 | Offset write strobe |
| ofs_sel_i | input | 1 | Offset select: 0 empty, 1 full |
| ofs_val_i | input | OFS_W | Offset value |
| dout_o | output | 18 | Read data (output register) |
| rd_flag_o | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| wr_flag_o | output | 1 | Full, active low (standard); input-ready, high when full (fall-through) |
| almost_empty_no | output | 1 | Almost-empty, active low |
| half_full_no | output | 1 | Half-full, active low |
| almost_full_no | output | 1 | Almost-full, active low |

## Verification
All flags decode registered state, so every flag settles on the rising edge that accepts a write, a read or an offset write. Data leaves through a register: in standard mode a read shows its word one edge after the request. In fall-through mode a word written into an empty FIFO appears two edges after the write, and each later consume refills the output on that same edge. The reference model advances on each rising edge using the inputs that were set up at the previous falling edge. Every output is compared at the next falling edge, which is exactly one register stage after the cause and clear of the clock edge.

// File: rtl/dm_fifo_pkg.sv
package dm_fifo_pkg;
  localparam int unsigned DATA_W = 18;
  localparam int unsigned DEF_WIDE   = 'h3FF;
  localparam int unsigned DEF_NARROW = 'h07F;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dm_fifo_mem.sv
module dm_fifo_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 18,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // output register: loaded only on a pop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dm_fifo_ctrl.sv
module dm_fifo_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wen_ni,
  input  logic          ren_ni,
  output logic          mem_we_o,
  output logic [AW-1:0] waddr_o,
  output logic          mem_re_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] occ_o,
  output logic          ov_o,
  output logic          full_o,
  output logic          mem_nz_o
);
  localparam logic [CW-1:0] CAP_STD  = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_FWFT = CW'(DEPTH + 1);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic [AW-1:0] wptr_q, rptr_q;
  logic          ov_q, ov_d;
  logic          wr_ok, pop, consume;

  assign cap     = fwft_i ? CAP_FWFT : CAP_STD;
  assign occ_o   = cnt_q + CW'(ov_q);
  assign full_o  = (occ_o == cap);
  assign wr_ok   = !wen_ni && !full_o;
  assign consume = fwft_i && ov_q && !ren_ni;

  always_comb begin
    if (fwft_i) pop = (cnt_q != '0) && (!ov_q || consume);
    else        pop = (cnt_q != '0) && !ren_ni;
    ov_d = ov_q;
    if (!fwft_i)     ov_d = 1'b0;
    else if (pop)    ov_d = 1'b1;
    else if (consume) ov_d = 1'b0;
    cnt_d = cnt_q + CW'(wr_ok) - CW'(pop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ov_q   <= 1'b0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ov_q  <= ov_d;
      if (wr_ok) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop)   rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    end
  end

  assign mem_we_o = wr_ok;
  assign waddr_o  = wptr_q;
  assign mem_re_o = pop;
  assign raddr_o  = rptr_q;
  assign ov_o     = ov_q;
  assign mem_nz_o = (cnt_q != '0);

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o <= cap);
  a_r9_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && ren_ni) |=> (occ_o == $past(occ_o)));
  a_r9_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft_i && cnt_q == '0 && wen_ni) |=> (cnt_q == '0));
  a_r4_fall_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && !ov_q && cnt_q != '0) |=> ov_q);
  a_r12_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && ov_q && !ren_ni && cnt_q != '0) |=> ov_q);
endmodule

// File: rtl/dm_fifo_ofs.sv
module dm_fifo_ofs #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dflt_sel_i,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [OFS_W-1:0] val_i,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);
  import dm_fifo_pkg::*;
  localparam int unsigned LIM    = DEPTH - 1;
  localparam logic [OFS_W-1:0] DEF_W = OFS_W'((DEF_WIDE   > LIM) ? LIM : DEF_WIDE);
  localparam logic [OFS_W-1:0] DEF_N = OFS_W'((DEF_NARROW > LIM) ? LIM : DEF_NARROW);

  // defaults track dflt_sel_i for every clock spent in reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ae_ofs_o <= dflt_sel_i ? DEF_W : DEF_N;
      af_ofs_o <= dflt_sel_i ? DEF_W : DEF_N;
    end else if (we_i) begin
      if (sel_i) af_ofs_o <= val_i;
      else       ae_ofs_o <= val_i;
    end
  end
endmodule

// File: rtl/dm_fifo_flags.sv
module dm_fifo_flags #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OFS_W = 10,
  localparam int unsigned CW   = $clog2(DEPTH + 2)
) (
  input  logic [CW-1:0]    occ_i,
  input  logic             fwft_i,
  input  logic [OFS_W-1:0] ae_ofs_i,
  input  logic [OFS_W-1:0] af_ofs_i,
  output logic             almost_empty_no,
  output logic             half_full_no,
  output logic             almost_full_no
);
  int k, s, n, m;
  always_comb begin
    k = int'(32'(occ_i));
    s = fwft_i ? 1 : 0;
    n = int'(32'(ae_ofs_i));
    m = int'(32'(af_ofs_i));
    almost_empty_no = (k >= n + 1 + s);
    half_full_no    = !(k >= int'(DEPTH / 2) + 1 + s);
    almost_full_no  = !(k >= int'(DEPTH) + s - m);
  end
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OFS_W = 10,
  localparam int unsigned DW   = dm_fifo_pkg::DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwft_mode_i,
  input  logic             dflt_sel_i,
  input  logic             wen_ni,
  input  logic             ren_ni,
  input  logic [DW-1:0]    din_i,
  input  logic             ofs_we_i,
  input  logic             ofs_sel_i,
  input  logic [OFS_W-1:0] ofs_val_i,
  output logic [DW-1:0]    dout_o,
  output logic             rd_flag_o,
  output logic             wr_flag_o,
  output logic             almost_empty_no,
  output logic             half_full_no,
  output logic             almost_full_no
);
  import dm_fifo_pkg::*;
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 2);

  fifo_mode_e    mode_q;
  logic          fwft;
  logic          mem_we, mem_re, ov, full, mem_nz;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] occ;
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(fwft_mode_i);
  end
  assign fwft = (mode_q == MODE_FWFT);

  dm_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i, .rst_ni, .fwft_i(fwft), .wen_ni, .ren_ni,
    .mem_we_o(mem_we), .waddr_o(waddr), .mem_re_o(mem_re), .raddr_o(raddr),
    .occ_o(occ), .ov_o(ov), .full_o(full), .mem_nz_o(mem_nz)
  );

  dm_fifo_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(waddr), .wdata_i(din_i),
    .re_i(mem_re), .raddr_i(raddr), .rdata_o(dout_o)
  );

  dm_fifo_ofs #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_ofs (
    .clk_i, .rst_ni, .dflt_sel_i, .we_i(ofs_we_i), .sel_i(ofs_sel_i),
    .val_i(ofs_val_i), .ae_ofs_o(ae_ofs), .af_ofs_o(af_ofs)
  );

  dm_fifo_flags #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_flags (
    .occ_i(occ), .fwft_i(fwft), .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs),
    .almost_empty_no, .half_full_no, .almost_full_no
  );

  // shared pins change meaning with the mode
  assign rd_flag_o = fwft ? !ov  : mem_nz;
  assign wr_flag_o = fwft ? full : !full;

  a_r1_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_q));
  a_r5_ready_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft && full) |-> ov);
endmodule

// File: tb/test_dm_fifo.sv
module test_dm_fifo;
  localparam int D = 256;
  localparam int OW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, dsel = 1'b0, wen_n = 1'b1, ren_n = 1'b1;
  logic [17:0] din = '0;
  logic owe = 1'b0, osel = 1'b0;
  logic [OW-1:0] oval = '0;
  logic [17:0] dout;
  logic rdf, wrf, ae_n, hf_n, af_n;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dm_fifo #(.DEPTH(D), .OFS_W(OW)) i_dm_fifo (
    .clk_i(clk), .rst_ni(rst_n), .fwft_mode_i(mode), .dflt_sel_i(dsel),
    .wen_ni(wen_n), .ren_ni(ren_n), .din_i(din), .ofs_we_i(owe),
    .ofs_sel_i(osel), .ofs_val_i(oval), .dout_o(dout), .rd_flag_o(rdf),
    .wr_flag_o(wrf), .almost_empty_no(ae_n), .half_full_no(hf_n),
    .almost_full_no(af_n)
  );

  // reference model
  int q[$];
  bit m_fwft = 0, m_ov = 0, m_dv = 0;
  int m_dout = 0, m_n = 0, m_m = 0;

  function automatic int clampd(int v);
    return (v > D - 1) ? D - 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_ov = 0; m_dv = 0;
      m_fwft = mode;
      m_n = dsel ? clampd('h3FF) : clampd('h07F);
      m_m = m_n;
    end else begin
      int occ, cap, memc;
      bit wr, cons, pop;
      occ  = q.size();
      cap  = m_fwft ? D + 1 : D;
      memc = occ - (m_fwft ? int'(m_ov) : 0);
      wr   = !wen_n && occ < cap;
      if (!m_fwft) begin
        if (!ren_n && occ > 0) begin m_dout = q.pop_front(); m_dv = 1; end
      end else begin
        cons = m_ov && !ren_n;
        pop  = memc > 0 && (!m_ov || cons);
        if (cons) void'(q.pop_front());
        if (pop) begin m_dout = q[0]; m_dv = 1; end
        m_ov = pop ? 1'b1 : (cons ? 1'b0 : m_ov);
      end
      if (wr) q.push_back(int'(din));
      if (owe) begin
        if (osel) m_m = int'(oval); else m_n = int'(oval);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output on each falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int k, s, cap;
      k = q.size(); s = m_fwft; cap = D + s;
      if (m_fwft) begin
        chk("R4 R12 output-ready", int'(rdf), int'(!m_ov));
        chk("R5 input-ready", int'(wrf), int'(k == cap));
      end else begin
        chk("R2 empty flag", int'(rdf), int'(k != 0));
        chk("R3 full flag", int'(wrf), int'(k != cap));
      end
      chk("R6 R11 almost-empty", int'(ae_n), int'(k >= m_n + 1 + s));
      chk("R7 half-full", int'(hf_n), int'(!(k >= D / 2 + 1 + s)));
      chk("R8 R10 almost-full", int'(af_n), int'(!(k >= cap - m_m)));
      if (m_dv && (!m_fwft || m_ov)) chk("R13 R9 data", int'(dout), m_dout);
    end
  end

  int seq = 1;

  task automatic do_reset(bit md, bit ds);
    @(negedge clk);
    rst_n = 1'b0; mode = md; dsel = ds; wen_n = 1'b1; ren_n = 1'b1; owe = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state per captured mode
    chk("R1 reset rd_flag", int'(rdf), md ? 1 : 0);
    chk("R1 reset wr_flag", int'(wrf), md ? 0 : 1);
    chk("R6 reset almost-empty", int'(ae_n), 0);
    chk("R7 reset half-full", int'(hf_n), 1);
    chk("R8 reset almost-full", int'(af_n), 1);
    rst_n = 1'b1;
  endtask

  task automatic step(bit w, bit r);
    wen_n = !w; ren_n = !r; din = 18'(seq);
    if (w) seq++;
    @(negedge clk);
    wen_n = 1'b1; ren_n = 1'b1;
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) step(1, 0);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      step(0, 1);
      // R12: with reads held, output stays valid while words remain
      if (m_fwft && q.size() > 0) chk("R12 no bubble", int'(rdf), 0);
    end
  endtask

  task automatic random_traffic(int n, int wbias);
    for (int i = 0; i < n; i++)
      step($urandom_range(0, 99) < wbias, $urandom_range(0, 1) == 1);
  endtask

  task automatic set_ofs(bit sel, int v);
    owe = 1'b1; osel = sel; oval = OW'(v);
    @(negedge clk);
    owe = 1'b0;
  endtask

  initial begin
    // standard mode, narrow defaults
    do_reset(1'b0, 1'b0);
    step(0, 1);                       // R9: read on empty ignored
    chk("R9 read on empty", int'(rdf), 0);
    step(1, 0);
    chk("R2 first write", int'(rdf), 1);
    fill(D + 3);                      // R9: extra writes dropped
    chk("R3 full after D", int'(wrf), 0);
    step(0, 1);
    chk("R3 first read from full", int'(wrf), 1);
    drain(D + 2);
    chk("R2 last read", int'(rdf), 0);
    random_traffic(1500, 60);
    random_traffic(1500, 40);

    // fall-through mode, wide defaults
    do_reset(1'b1, 1'b1);
    mode = 1'b0;                      // R1: ignored out of reset
    wen_n = 1'b0; din = 18'(seq); seq++;
    @(negedge clk);
    wen_n = 1'b1;
    chk("R4 not yet ready", int'(rdf), 1);
    @(negedge clk);
    chk("R4 ready without read", int'(rdf), 0);
    chk("R4 first word", int'(dout), seq - 1);
    fill(D + 3);
    chk("R5 full at D+1", int'(wrf), 1);
    chk("R10 wide default almost-full", int'(af_n), 0);
    drain(D + 3);
    chk("R4 empty after last", int'(rdf), 1);
    random_traffic(1500, 60);

    // offset port in fall-through mode
    set_ofs(1'b0, 5);
    set_ofs(1'b1, 3);
    random_traffic(300, 55);
    drain(D + 2);
    fill(7);
    chk("R11 ae at n+2", int'(ae_n), 1);
    drain(1);
    chk("R11 ae at n+1", int'(ae_n), 0);
    fill(D);
    random_traffic(1500, 50);

    // standard mode with new offsets and wide defaults
    do_reset(1'b0, 1'b1);
    set_ofs(1'b0, 9);
    set_ofs(1'b1, 20);
    random_traffic(3000, 52);
    fill(D);
    drain(D + 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule